// File: doc/BRIEF.md
# APB UART Register Front End

This block is the register side of a byte-oriented UART, placed on an APB bus. The serial engine sits outside it and exchanges whole bytes through two valid/ready streams. Received bytes go into a deep receive queue until software reads them. A CPU write to the data register sends one byte out on the transmit stream. A single interrupt line tells the CPU that a byte has arrived or has left.

Software sees three live registers: data, status and control. The data register can also be reached at byte offset 3, so a byte-wide access works the same way as a word access. Only the low eight address bits are decoded. Reset puts control at zero, reports an empty transmitter and empties the receive queue. The control register stores mode bits for parity, flow control, loopback, clock source, queue interrupts, debug and output enable. Those bits can be read back, but they do nothing here.

Stream rules. Receive: a byte moves on any edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low only when the queue holds the full `RXQ_DEPTH` bytes, so back-pressure stops the source rather than losing data. A byte that moves while receive is disabled is consumed and thrown away. Transmit: `tx_valid` is a one-cycle offer that lines up with the APB access phase of a data write. The byte moves only if `tx_ready` is high in that cycle. The offer is never held or repeated, so a byte offered while `tx_ready` is low is lost.

Top module: `apbuart_regif`

## Requirements
- R1: After reset, control reads 0x0000_0000 and status reads 0x0000_0006 (bits 1 and 2 set). The receive queue is empty, `irq` is low and `rx_ready` is high.
- R2: Decoding uses `paddr[7:0]` only. 0x00 and 0x03 both reach the data register, 0x04 is status and 0x08 is control. Every other offset (including 0x0C and 0x10) reads zero, and writes to it have no effect.
- R3: A write to control (0x08) replaces it. Bits 0..12 and bit 31 are stored and every other bit reads 0, so writing 0xFFFF_FFFF reads back 0x8000_1FFF.
- R4: Status is read-only. A write to 0x04 leaves every status bit unchanged.
- R5: A receive handshake stores the byte only when control bit 0 (receive enable) is set. Otherwise the byte is dropped and the queue stays empty.
- R6: A read of the data register returns the oldest stored byte in bits 7:0, with the upper bits zero, and removes that byte. Bytes come out in arrival order.
- R7: Status bit 0 (data ready) is set while the queue holds a byte. Removing the last byte clears it. A data read of an empty queue returns 0.
- R8: Status bit 8 is set while the queue holds at least `RXQ_DEPTH/2` bytes. Status bit 10 is set, and `rx_ready` is low, while the queue holds `RXQ_DEPTH` bytes.
- R9: A data write with control bit 1 (transmit enable) set raises `tx_valid` for its access cycle, with `tx_data` = `pwdata[7:0]`. The byte transfers only if `tx_ready` is high. With bit 1 clear, no offer is made.
- R10: `irq` goes high for one cycle, in the cycle after either of these events. Coincident events give a single pulse, and no other cause raises it.
  - a stored receive byte, when control bit 2 is set
  - a transferred transmit byte, when control bit 3 is set
- R11: Every APB transfer completes with zero wait states: `pready` is high and `pslverr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | ADDR_W | Byte address (low 8 bits decoded) |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done (always high) |
| pslverr | output | 1 | Transfer error (always low) |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Queue has space |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink accepts byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The checker assumes the following about the inputs:
- The receive source keeps a byte from moving while `rx_ready` is low.
- APB accesses follow the setup-then-access order.
- The bus is never left in an access phase across reset.

The bench drives all inputs on the falling edge, one APB transfer at a time. It offers receive bytes only after seeing `rx_ready` high, and it never pushes beyond the queue depth. It puts a receive handshake and a data write into the same edge only in the dedicated coincidence test, so each interrupt pulse can be traced to its cause.

// File: rtl/apbuart_pkg.sv
package apbuart_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DATA_B = 8'h03;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;

  // stored bits of the control register
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h8000_1FFF;

  // control bit positions that have an effect
  localparam int CB_RX_EN = 0;
  localparam int CB_TX_EN = 1;
  localparam int CB_RX_IE = 2;
  localparam int CB_TX_IE = 3;

  // status bit positions
  localparam int SB_DREADY   = 0;
  localparam int SB_TSH_MT   = 1;
  localparam int SB_TQ_MT    = 2;
  localparam int SB_RQ_HALF  = 8;
  localparam int SB_RQ_FULL  = 10;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL
  } regsel_e;

  function automatic regsel_e decode_ofs(input logic [7:0] ofs);
    case (ofs)
      OFS_DATA, OFS_DATA_B: decode_ofs = SEL_DATA;
      OFS_STAT:             decode_ofs = SEL_STAT;
      OFS_CTRL:             decode_ofs = SEL_CTRL;
      default:              decode_ofs = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/apbuart_rxq.sv
module apbuart_rxq #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output logic             half
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign half  = (count >= CNT_W'(DEPTH / 2));

endmodule

// File: rtl/apbuart_ctrlreg.sv
module apbuart_ctrlreg
  import apbuart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl <= '0;
    else if (we) ctrl <= wdata & CTRL_KEEP;
  end

endmodule

// File: rtl/apbuart_irqgen.sv
module apbuart_irqgen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_evt,
  input  logic rx_ie,
  input  logic tx_evt,
  input  logic tx_ie,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (rx_evt & rx_ie) | (tx_evt & tx_ie);
  end

endmodule

// File: rtl/apbuart_rdmux.sv
module apbuart_rdmux
  import apbuart_pkg::*;
(
  input  regsel_e           sel,
  input  logic              q_empty,
  input  logic [BYTE_W-1:0] q_head,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] rdata
);

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_DATA: rdata = q_empty ? '0 : {{(DATA_W-BYTE_W){1'b0}}, q_head};
      SEL_STAT: rdata = status;
      SEL_CTRL: rdata = ctrl;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/apbuart_regif.sv
module apbuart_regif
  import apbuart_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int RXQ_DEPTH = 1024,
  localparam int CNT_W    = $clog2(RXQ_DEPTH + 1)
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);

  regsel_e           sel;
  logic              access, rd_data, wr_data, wr_ctrl;
  logic              rx_store, q_pop, tx_fire;
  logic [DATA_W-1:0] ctrl_q, status;
  logic [BYTE_W-1:0] q_head;
  logic [CNT_W-1:0]  rxq_count;
  logic              q_empty, q_full, q_half;
  logic              dready_q;

  assign sel     = decode_ofs(paddr[7:0]);
  assign access  = psel & penable;
  assign rd_data = access & ~pwrite & (sel == SEL_DATA);
  assign wr_data = access &  pwrite & (sel == SEL_DATA);
  assign wr_ctrl = access &  pwrite & (sel == SEL_CTRL);

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  // receive path
  assign rx_ready = ~q_full;
  assign rx_store = rx_valid & rx_ready & ctrl_q[CB_RX_EN];
  assign q_pop    = rd_data & ~q_empty;

  apbuart_rxq #(.DEPTH(RXQ_DEPTH), .WIDTH(BYTE_W)) u_rxq (
    .clk       (pclk),
    .rst_n     (presetn),
    .push      (rx_store),
    .push_data (rx_data),
    .pop       (q_pop),
    .head      (q_head),
    .count     (rxq_count),
    .empty     (q_empty),
    .full      (q_full),
    .half      (q_half)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                                         dready_q <= 1'b0;
    else if (rx_store)                                    dready_q <= 1'b1;
    else if (rd_data && rxq_count <= CNT_W'(1))           dready_q <= 1'b0;
  end

  // transmit path
  assign tx_valid = wr_data & ctrl_q[CB_TX_EN];
  assign tx_data  = pwdata[7:0];
  assign tx_fire  = tx_valid & tx_ready;

  apbuart_ctrlreg u_ctrl (
    .clk   (pclk),
    .rst_n (presetn),
    .we    (wr_ctrl),
    .wdata (pwdata),
    .ctrl  (ctrl_q)
  );

  always_comb begin
    status             = '0;
    status[SB_DREADY]  = dready_q;
    status[SB_TSH_MT]  = 1'b1;
    status[SB_TQ_MT]   = 1'b1;
    status[SB_RQ_HALF] = q_half;
    status[SB_RQ_FULL] = q_full;
  end

  apbuart_rdmux u_rdmux (
    .sel     (sel),
    .q_empty (q_empty),
    .q_head  (q_head),
    .status  (status),
    .ctrl    (ctrl_q),
    .rdata   (prdata)
  );

  apbuart_irqgen u_irq (
    .clk    (pclk),
    .rst_n  (presetn),
    .rx_evt (rx_store),
    .rx_ie  (ctrl_q[CB_RX_IE]),
    .tx_evt (tx_fire),
    .tx_ie  (ctrl_q[CB_TX_IE]),
    .irq    (irq)
  );

endmodule

// File: rtl/apbuart_regif_chk.sv
module apbuart_regif_chk #(
  parameter int DEPTH = 1024,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [31:0]      ctrl,
  input logic [CNT_W-1:0] count,
  input logic             dready,
  input logic             pready,
  input logic             pslverr
);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((rx_valid && rx_ready && ctrl[0] && ctrl[2]) ||
                  (tx_valid && tx_ready && ctrl[3])));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R5
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count > $past(count)) |-> $past(ctrl[0] && rx_valid && rx_ready));

  // R7
  dready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dready == (count != '0));

  // R9
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ctrl[1]);

  // R11
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

endmodule

bind apbuart_regif apbuart_regif_chk #(.DEPTH(RXQ_DEPTH)) u_regif_chk (
  .clk      (pclk),
  .rst_n    (presetn),
  .irq      (irq),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .ctrl     (ctrl_q),
  .count    (rxq_count),
  .dready   (dready_q),
  .pready   (pready),
  .pslverr  (pslverr)
);

// File: tb/apbuart_regif_bench.sv
`timescale 1ns/1ps
module apbuart_regif_bench;

  localparam int ADDR_W = 12;
  localparam int DEPTH  = 1024;

  logic              pclk = 1'b0;
  logic              presetn = 1'b0;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic              pready, pslverr;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_ready;
  logic              tx_valid;
  logic [7:0]        tx_data;
  logic              tx_ready = 1'b1;
  logic              irq;

  always #4 pclk = ~pclk;

  apbuart_regif #(.ADDR_W(ADDR_W), .RXQ_DEPTH(DEPTH)) u_apbuart_regif (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .pready, .pslverr, .rx_valid, .rx_data, .rx_ready, .tx_valid, .tx_data,
    .tx_ready, .irq
  );

  int nvec = 0;
  int nerr = 0;
  int irq_hi = 0;
  logic [31:0] ctrl_m = '0;
  logic [7:0]  rx_q[$];
  logic [7:0]  tx_q[$];
  logic [31:0] rd;

  function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endfunction

  // monitor: scoreboard for received bytes, transmitted bytes, irq width
  always @(negedge pclk) begin
    if (irq) irq_hi++;
    if (presetn && psel && penable && !pwrite &&
        (paddr[7:0] == 8'h00 || paddr[7:0] == 8'h03)) begin
      if (rx_q.size() == 0) chk("R7 empty read", prdata, 32'h0);
      else                  chk("R6 rx order", prdata, {24'h0, rx_q.pop_front()});
    end
    if (presetn && tx_valid) begin
      if (!ctrl_m[1]) chk("R9 offer while disabled", 32'(tx_valid), 32'h0);
      else if (tx_ready) begin
        if (tx_q.size() == 0) chk("R9 unexpected byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
        else                  chk("R9 tx byte", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
      end
    end
  end

  task automatic apb(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                     output logic [31:0] r);
    @(negedge pclk);
    psel = 1'b1; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    r = prdata;
    if (!pready || pslverr) chk("R11 wait/error", {30'h0, pready, pslverr}, 32'h2);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    if (a[7:0] == 8'h08) ctrl_m = d & 32'h8000_1FFF;
    if ((a[7:0] == 8'h00 || a[7:0] == 8'h03) && ctrl_m[1] && tx_ready)
      tx_q.push_back(d[7:0]);
    apb(1'b1, a, d, dummy);
  endtask

  task automatic rd_reg(input logic [ADDR_W-1:0] a, output logic [31:0] r);
    apb(1'b0, a, 32'h0, r);
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge pclk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge pclk);
    if (ctrl_m[0]) rx_q.push_back(b);
    @(negedge pclk);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge pclk);
  endtask

  logic done = 1'b0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    rd_reg(12'h004, rd); chk("R1 status", rd, 32'h6);
    rd_reg(12'h008, rd); chk("R1 control", rd, 32'h0);
    chk("R1 irq/rx_ready", {30'h0, irq, rx_ready}, 32'h1);

    // R5 receive disabled drops bytes
    send_rx(8'h11);
    rd_reg(12'h004, rd); chk("R5 status after drop", rd, 32'h6);
    rd_reg(12'h000, rd);

    // R10 receive interrupt, R7 data ready
    wr_reg(12'h008, 32'h5);
    base = irq_hi;
    send_rx(8'h5A);
    settle();
    chk("R10 rx pulse", 32'(irq_hi - base), 32'h1);
    rd_reg(12'h004, rd); chk("R7 ready set", rd, 32'h7);
    rd_reg(12'h000, rd);
    rd_reg(12'h004, rd); chk("R7 ready cleared", rd, 32'h6);

    // R6 order, R2 alias at offset 3
    send_rx(8'h01); send_rx(8'h02); send_rx(8'h03);
    rd_reg(12'h003, rd); chk("R2 alias", rd, 32'h1);
    rd_reg(12'h000, rd);
    rd_reg(12'h003, rd);
    rd_reg(12'h000, rd);
    rd_reg(12'h004, rd); chk("R7 after drain", rd, 32'h6);

    // R2 other offsets, upper address bits
    wr_reg(12'h00C, 32'hFFFF_FFFF);
    rd_reg(12'h00C, rd); chk("R2 scaler", rd, 32'h0);
    rd_reg(12'h010, rd); chk("R2 debug", rd, 32'h0);
    rd_reg(12'h01C, rd); chk("R2 unmapped", rd, 32'h0);
    rd_reg(12'h104, rd); chk("R2 upper bits ignored", rd, 32'h6);

    // R4 status read-only
    wr_reg(12'h004, 32'hFFFF_FFFF);
    rd_reg(12'h004, rd); chk("R4 status write", rd, 32'h6);

    // R3 control mask
    wr_reg(12'h008, 32'hFFFF_FFFF);
    rd_reg(12'h008, rd); chk("R3 control mask", rd, 32'h8000_1FFF);

    // R9 transmit with interrupt
    wr_reg(12'h008, 32'hA);
    base = irq_hi;
    wr_reg(12'h000, 32'h0000_01A5);
    settle();
    chk("R10 tx pulse", 32'(irq_hi - base), 32'h1);
    chk("R9 tx delivered", 32'(tx_q.size()), 32'h0);
    tx_ready = 1'b0;
    base = irq_hi;
    wr_reg(12'h003, 32'h33);
    settle();
    chk("R9 dropped when sink busy", 32'(irq_hi - base), 32'h0);
    tx_ready = 1'b1;
    wr_reg(12'h008, 32'h8);
    base = irq_hi;
    wr_reg(12'h000, 32'h44);
    settle();
    chk("R9 tx disabled no pulse", 32'(irq_hi - base), 32'h0);

    // R10 coincident rx and tx give one pulse
    wr_reg(12'h008, 32'hF);
    base = irq_hi;
    tx_q.push_back(8'h77);
    rx_q.push_back(8'h88);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h000; pwdata = 32'h77;
    @(negedge pclk);
    penable = 1'b1; rx_valid = 1'b1; rx_data = 8'h88;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
    settle();
    chk("R10 coincident single pulse", 32'(irq_hi - base), 32'h1);
    rd_reg(12'h000, rd);

    // R8 level flags and back-pressure
    wr_reg(12'h008, 32'h1);
    for (int i = 0; i < DEPTH / 2 - 1; i++) send_rx(8'(i));
    rd_reg(12'h004, rd); chk("R8 below half", rd, 32'h7);
    send_rx(8'(DEPTH / 2 - 1));
    rd_reg(12'h004, rd); chk("R8 half", rd, 32'h107);
    for (int i = DEPTH / 2; i < DEPTH; i++) send_rx(8'(i));
    rd_reg(12'h004, rd); chk("R8 full", rd, 32'h507);
    @(negedge pclk);
    chk("R8 rx_ready low", 32'(rx_ready), 32'h0);
    rd_reg(12'h000, rd);
    @(negedge pclk);
    chk("R8 rx_ready back", 32'(rx_ready), 32'h1);
    for (int i = 1; i < DEPTH; i++) rd_reg(12'h000, rd);
    rd_reg(12'h004, rd); chk("R7 drained", rd, 32'h6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule